// File: doc/BRIEF.md
# Mode-Dependent Transfer Counter

This unit keeps the remaining-transfer count for one channel of a descriptor-driven data mover. Software, by way of the descriptor fetch logic, loads a 16-bit value. Each completed data transfer then strobes the unit once. The current contents appear on `count_o` every cycle so that the controller can write them back to the descriptor.

The mode input decides how the 16 bits are interpreted. In normal mode they form a single down-counter, and a value of zero stands for 65536 transfers. In repeat and block modes the upper byte is a fixed reload value and the lower byte counts down. When the lower byte would reach zero, it is refilled from the upper byte. A zero byte stands for 256.

Event outputs are one-cycle pulses. They mark the end of a normal run, the end of each repeat period, and the end of each block. A strobe in the reserved mode raises an error flag instead of counting.

Top module: `xcu_top`

## Requirements
- R1: While reset is active, and for the cycles after it until the first load, `count_o` reads 0 and every pulse output and `mode_err_o` are low.
- R2: When `load_i` is high at a clock edge, `count_o` shows `load_val_i` from the next cycle. A load also clears `mode_err_o`, and it wins over a `xfer_i` strobe in the same cycle.
- R3: A `xfer_i` strobe that arrives before any load has no effect on `count_o`.
- R4: With `mode_i` = 2'b00 (normal), each strobe lowers the full 16-bit count by one. A count of 0000h goes to FFFFh, so a loaded 0000h allows 65536 transfers.
- R5: In normal mode the strobe that moves the count from 0001h to 0000h raises `end_xfer_o` for exactly the one cycle in which 0000h first shows. After that, strobes leave the count at 0000h until the next load.
- R6: With `mode_i` = 2'b01 (repeat), a strobe lowers bits [7:0] by one and leaves bits [15:8] alone. When bits [7:0] are 01h, the strobe instead copies bits [15:8] into bits [7:0] and raises `end_rpt_o` for the cycle in which the copied value shows.
- R7: With `mode_i` = 2'b10 (block), the lower byte behaves as in R6, but the reload pulse appears on `end_blk_o`.
- R8: In repeat and block modes a lower byte of 00h goes to FFh on a strobe, so 00h counts as 256. An upper byte of 00h reloads 00h, which gives 256 transfers per period.
- R9: With `mode_i` = 2'b11 (reserved), a strobe without a load leaves `count_o` unchanged and sets `mode_err_o`. The flag stays high until the next load.
- R10: At most one event pulse is high in any cycle, and a pulse is high only in the cycle after a strobe that was not accompanied by a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | 00 normal, 01 repeat, 10 block, 11 reserved |
| load_i | input | 1 | Load strobe for `load_val_i` |
| load_val_i | input | 16 | Value to load |
| xfer_i | input | 1 | One-cycle strobe per completed data transfer |
| count_o | output | 16 | Current counter contents, for write-back |
| end_xfer_o | output | 1 | Normal-mode run finished |
| end_rpt_o | output | 1 | Repeat-mode reload happened |
| end_blk_o | output | 1 | Block-mode reload happened |
| mode_err_o | output | 1 | Sticky flag: strobe seen in reserved mode |

## Verification
The bench walks a loaded zero through all 65536 normal-mode decrements. A design that read zero as "empty" would fire `end_xfer_o` at once, and one that wrapped wrongly would finish early.

In repeat and block modes it runs through several reloads, including a 00h lower byte and a 00h upper byte. Reloading one cycle late would show a 00h lower byte for a cycle, and treating 00h as empty would skip the 256-count period.

It also checks three more cases:
- A load and a strobe in the same cycle. Getting the priority wrong would leave `count_o` one below the loaded value.
- Strobes after a normal run has finished. A design that did not hold at zero would wrap to FFFFh.
- Strobes in the reserved mode. A design that counted there would change `count_o`, and one whose error flag was not sticky would drop `mode_err_o`.

// File: rtl/xcu_pkg.sv
package xcu_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_REPEAT = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  typedef struct packed {
    logic run_end;
    logic rpt_end;
    logic blk_end;
  } evt_t;
endpackage

// File: rtl/xcu_rst_sync.sv
module xcu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xcu_wide_next.sv
// Next value of the full-width down-counter; wraps 0 -> all ones.
module xcu_wide_next #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    nxt  = cur - ONE;
    last = (cur == ONE);
  end
endmodule

// File: rtl/xcu_half_next.sv
// Next value when the upper half is a reload value and the lower half counts.
module xcu_half_next #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  localparam int HW = W / 2;
  localparam logic [HW-1:0] ONE_H = HW'(1);

  logic [HW-1:0] hi, lo;

  always_comb begin
    hi   = cur[W-1:HW];
    lo   = cur[HW-1:0];
    wrap = (lo == ONE_H);
    if (wrap) nxt = {hi, hi};
    else      nxt = {hi, lo - ONE_H};
  end
endmodule

// File: rtl/xcu_top.sv
module xcu_top
  import xcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             xfer_i,
  output logic [CNT_W-1:0] count_o,
  output logic             end_xfer_o,
  output logic             end_rpt_o,
  output logic             end_blk_o,
  output logic             mode_err_o
);
  logic rst_sync_n;

  xcu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             err_q, err_d;
  evt_t             evt_q, evt_d;
  logic             cnt_en, armed_en, err_en;

  logic [CNT_W-1:0] wide_nxt, half_nxt;
  logic             wide_last, half_wrap;
  xfer_mode_e       mode;

  assign mode = xfer_mode_e'(mode_i);

  xcu_wide_next #(.W(CNT_W)) u_wide (
    .cur(cnt_q), .nxt(wide_nxt), .last(wide_last)
  );

  xcu_half_next #(.W(CNT_W)) u_half (
    .cur(cnt_q), .nxt(half_nxt), .wrap(half_wrap)
  );

  // next-state logic
  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    err_d   = err_q;
    evt_d   = '0;
    if (load_i) begin
      cnt_d   = load_val_i;
      armed_d = 1'b1;
      err_d   = 1'b0;
    end else if (xfer_i) begin
      unique case (mode)
        XM_NORMAL: if (armed_q) begin
          cnt_d = wide_nxt;
          if (wide_last) begin
            evt_d.run_end = 1'b1;
            armed_d       = 1'b0;
          end
        end
        XM_REPEAT: if (armed_q) begin
          cnt_d         = half_nxt;
          evt_d.rpt_end = half_wrap;
        end
        XM_BLOCK: if (armed_q) begin
          cnt_d         = half_nxt;
          evt_d.blk_end = half_wrap;
        end
        XM_RSVD: err_d = 1'b1;
        default: err_d = 1'b1;
      endcase
    end
  end

  // clock enables
  assign cnt_en   = load_i | (xfer_i & armed_q & (mode != XM_RSVD));
  assign armed_en = load_i | (xfer_i & (mode == XM_NORMAL));
  assign err_en   = load_i | (xfer_i & (mode == XM_RSVD));

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) evt_q <= '0;
    else             evt_q <= evt_d;
  end

  assign count_o    = cnt_q;
  assign end_xfer_o = evt_q.run_end;
  assign end_rpt_o  = evt_q.rpt_end;
  assign end_blk_o  = evt_q.blk_end;
  assign mode_err_o = err_q;
endmodule

// File: rtl/xcu_chk.sv
module xcu_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [1:0]       mode_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic             xfer_i,
  input logic [CNT_W-1:0] count_o,
  input logic             end_xfer_o,
  input logic             end_rpt_o,
  input logic             end_blk_o,
  input logic             mode_err_o
);
  localparam int HW = CNT_W / 2;

  logic any_evt;
  assign any_evt = end_xfer_o | end_rpt_o | end_blk_o;

  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_i |=> (count_o == $past(load_val_i)));  // R2

  AST_LOAD_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_i |=> !mode_err_o);  // R2

  AST_RUN_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    end_xfer_o |-> (count_o == '0));  // R5

  AST_RPT_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_i == 2'b01 && !load_i) |=> $stable(count_o[CNT_W-1:HW]));  // R6

  AST_RELOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (end_rpt_o || end_blk_o) |-> (count_o[HW-1:0] == count_o[CNT_W-1:HW]));  // R7

  AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_i == 2'b11 && !load_i) |=> $stable(count_o));  // R9

  AST_RSVD_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_i == 2'b11 && xfer_i && !load_i) |=> mode_err_o);  // R9

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({end_xfer_o, end_rpt_o, end_blk_o}));  // R10

  AST_EVENT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    any_evt |-> $past(xfer_i && !load_i));  // R10
endmodule

bind xcu_top xcu_chk #(.CNT_W(CNT_W)) u_xcu_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .mode_i(mode_i), .load_i(load_i),
  .load_val_i(load_val_i), .xfer_i(xfer_i), .count_o(count_o),
  .end_xfer_o(end_xfer_o), .end_rpt_o(end_rpt_o), .end_blk_o(end_blk_o),
  .mode_err_o(mode_err_o)
);

// File: tb/tb_xcu_top.sv
module tb_xcu_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        load_i;
  logic [15:0] load_val_i;
  logic        xfer_i;
  logic [15:0] count_o;
  logic        end_xfer_o, end_rpt_o, end_blk_o, mode_err_o;

  xcu_top dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .load_i(load_i),
    .load_val_i(load_val_i), .xfer_i(xfer_i), .count_o(count_o),
    .end_xfer_o(end_xfer_o), .end_rpt_o(end_rpt_o), .end_blk_o(end_blk_o),
    .mode_err_o(mode_err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_armed = 0;
  bit m_err = 0;
  bit m_run = 0, m_rpt = 0, m_blk = 0;

  task automatic model_step(input int md, input bit ld, input int v, input bit x);
    int lo, hi;
    m_run = 0; m_rpt = 0; m_blk = 0;
    if (ld) begin
      m_cnt = v; m_armed = 1; m_err = 0;
    end else if (x) begin
      if (md == 3) m_err = 1;
      else if (m_armed) begin
        if (md == 0) begin
          if (m_cnt == 1) begin m_run = 1; m_armed = 0; end
          m_cnt = (m_cnt + 65535) % 65536;
        end else begin
          hi = m_cnt / 256;
          lo = m_cnt % 256;
          if (lo == 1) begin
            lo = hi;
            if (md == 1) m_rpt = 1; else m_blk = 1;
          end else lo = (lo + 255) % 256;
          m_cnt = hi * 256 + lo;
        end
      end
    end
  endtask

  task automatic check(input string tag);
    logic [19:0] act, exp;
    act = {count_o, end_xfer_o, end_rpt_o, end_blk_o, mode_err_o};
    exp = {m_cnt[15:0], m_run, m_rpt, m_blk, m_err};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: cnt/run/rpt/blk/err actual %h %b%b%b%b expected %h %b%b%b%b",
               tag, act[19:4], act[3], act[2], act[1], act[0],
               exp[19:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input int md, input bit ld, input int v, input bit x, input string tag);
    mode_i = md[1:0]; load_i = ld; load_val_i = v[15:0]; xfer_i = x;
    @(posedge clk);
    model_step(md, ld, v, x);
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'b00; load_i = 1'b0; load_val_i = '0; xfer_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R1");

    // strobes before any load
    cyc(0, 0, 0, 1, "R3");
    cyc(1, 0, 0, 1, "R3");
    cyc(2, 0, 0, 1, "R3");

    // normal: load 3, run out, then extra strobes
    cyc(0, 1, 16'h0003, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 0, "R5");

    // load beats a strobe in the same cycle
    cyc(0, 1, 16'h1234, 1, "R2");
    cyc(0, 0, 0, 1, "R4");
    cyc(0, 1, 16'hFFFF, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, "R4");

    // zero encodes 65536: full run
    cyc(0, 1, 16'h0000, 0, "R2");
    for (int i = 0; i < 65536; i++) cyc(0, 0, 0, 1, "R4");
    cyc(0, 0, 0, 1, "R5");

    // repeat mode, period 3, with idle gaps
    cyc(1, 1, 16'h0303, 0, "R2");
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, (i % 3) != 2, "R6");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 1, "R6");

    // block mode, size 2
    cyc(2, 1, 16'h0202, 0, "R2");
    for (int i = 0; i < 7; i++) cyc(2, 0, 0, 1, "R7");
    // block size 1: pulse every strobe
    cyc(2, 1, 16'h0101, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(2, 0, 0, 1, "R7");

    // 256 encodings
    cyc(1, 1, 16'h0000, 0, "R2");
    for (int i = 0; i < 300; i++) cyc(1, 0, 0, 1, "R8");
    cyc(2, 1, 16'h0500, 0, "R2");
    for (int i = 0; i < 10; i++) cyc(2, 0, 0, 1, "R8");

    // reserved mode
    cyc(1, 1, 16'h0404, 0, "R2");
    cyc(3, 0, 0, 0, "R9");
    cyc(3, 0, 0, 1, "R9");
    cyc(3, 0, 0, 1, "R9");
    cyc(1, 0, 0, 1, "R9");
    cyc(0, 0, 0, 0, "R9");
    cyc(3, 1, 16'h0707, 1, "R2");
    cyc(3, 0, 0, 0, "R9");
    cyc(3, 0, 0, 1, "R9");
    cyc(0, 1, 16'h0002, 0, "R2");
    cyc(0, 0, 0, 1, "R10");
    cyc(0, 0, 0, 1, "R10");
    cyc(0, 0, 0, 0, "R10");

    finish_run();
  end
endmodule